// File: doc/BRIEF.md
# Serial Byte Transmitter with DMA Request

This block sends bytes on a single asynchronous serial line. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts a fixed number of clock cycles, which is set by a parameter. Bytes enter through a write strobe. A DMA engine or software can drive that strobe. The block raises a request line whenever it can take another byte, so a DMA channel can keep the line busy without software stepping in.

There are two queueing modes. In single-register mode, one byte waits behind the shifter, and the request follows the "register empty" flag. In queue mode, up to eight bytes wait in order, and the request follows the "queue not full" flag.

A transmission-complete flag tells software when the line has gone quiet after the last queued frame. Software must see this flag high before it disables the block. Software clears the flag with a one-cycle clear strobe. Each time the block is enabled, it first drives the line high for one whole frame time (the idle preamble), and only then starts the first frame.

Top module: `uart_tx_dma`

## Requirements
- R1: After reset, the block drives these values:
  - `txLine` is high.
  - `txEmpty`, `fifoNotFull` and `txComplete` are 1.
  - `dmaReq` is 0.
- R2: Each frame has this layout on `txLine`:
  - one start bit at 0;
  - eight data bits, bit 0 first;
  - one stop bit at 1.

  Each bit lasts `CLKS_PER_BIT` cycles. When another byte is already waiting at the end of a stop bit, its start bit follows with no idle gap, so frame starts are exactly 10·`CLKS_PER_BIT` cycles apart.
- R3: After the clock edge that samples `txEnable` going from low to high, `txLine` stays high for at least 10·`CLKS_PER_BIT` cycles before any start bit. Bytes written during this time wait in the queue.
- R4: In single-register mode (`fifoMode`=0):
  - At most one byte waits behind the shifter.
  - `txEmpty` is 1 exactly when no byte is waiting, and `dmaReq` equals `txEnable` AND `txEmpty`.
  - A write while a byte is already waiting is dropped and never sent.
- R5: In queue mode (`fifoMode`=1):
  - Up to 8 bytes wait and are sent in the order they were written.
  - `fifoNotFull` is 0 only when 8 bytes are waiting, and `dmaReq` equals `txEnable` AND `fifoNotFull`.
  - `txEmpty` still reports an empty queue.
  - A write to a full queue is dropped.
- R6: `dmaReq` is 0 whenever `txEnable` is 0, even when there is room for another byte.
- R7: An accepted write drives `txComplete` to 0 on the following cycle. This holds even while a frame is shifting.
- R8: `txComplete` becomes 1 only at the end of a stop bit when no byte is waiting. It stays 0 between frames that were queued back to back.
- R9: A one-cycle pulse on `clrTc` drives `txComplete` to 0 on the next cycle. It then stays 0 until a later frame completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Enables the transmitter; a rise starts the idle preamble |
| fifoMode | input | 1 | 1 selects the 8-entry queue; 0 selects the single register |
| wrValid | input | 1 | One-cycle write strobe for the data register |
| wrData | input | 8 | Byte to send |
| clrTc | input | 1 | Clear strobe for the transmission-complete flag |
| txLine | output | 1 | Serial output; idles high |
| dmaReq | output | 1 | DMA request: the block can take another byte |
| txEmpty | output | 1 | No byte is waiting behind the shifter |
| fifoNotFull | output | 1 | The waiting storage has room for another byte |
| txComplete | output | 1 | Transmission-complete flag |

## Verification
Two kinds of internal fault show up at the ports:
- A wrong queue count or pointer shows up at the serial line within one frame time. The decoded frames no longer match the ordered list of accepted bytes: a byte is lost, repeated or out of order. A wrong count also shows up at once in the `dmaReq` and `txEmpty` levels sampled right after a write.
- A fault in the bit counters or the state machine shows up as a wrong start-bit time, a wrong preamble length, or a wrong spacing between back-to-back frames. All of these are measured in cycles from the clock edge that causes them.

A fault in the completion flag shows up one cycle after a write or a clear strobe. It also shows up as a rise that happens before the scoreboard has drained.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic push;   // store the incoming byte
    logic load;   // move the oldest waiting byte into the shifter
    logic shift;  // advance the shifter by one bit
    logic abort;  // force the shifter back to idle (line high)
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PRE   = 2'd1,
    ST_READY = 2'd2,
    ST_SEND  = 2'd3
  } txState_t;

endpackage

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic              fifoMode,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine,
  output logic              qEmpty,
  output logic              qNotFull
);

  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int SHIFT_W = DATA_W + 2;

  logic [DATA_W-1:0]  mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic [CNT_W-1:0]   qCount, capacity;
  logic [SHIFT_W-1:0] shiftReg;

  // Pointer wrap: a power-of-two depth wraps by itself, any other depth compares.
  generate
    if ((FIFO_DEPTH & (FIFO_DEPTH - 1)) == 0) begin : gWrapPow2
      assign wrPtrNext = wrPtr + 1'b1;
      assign rdPtrNext = rdPtr + 1'b1;
    end else begin : gWrapCmp
      assign wrPtrNext = (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdPtrNext = (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  assign capacity = fifoMode ? CNT_W'(FIFO_DEPTH) : CNT_W'(1);
  assign qEmpty   = (qCount == '0);
  assign qNotFull = (qCount < capacity);

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtrNext;
      if (stb.load) rdPtr <= rdPtrNext;
      case ({stb.push, stb.load})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // Shifter: bit 0 is on the line; ones fill in from the top so idle is high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (stb.abort) begin
      shiftReg <= '1;
    end else if (stb.load) begin
      shiftReg <= {1'b1, mem[rdPtr], 1'b0};
    end else if (stb.shift) begin
      shiftReg <= {1'b1, shiftReg[SHIFT_W-1:1]};
    end
  end

  assign txLine = shiftReg[0];

  assert_no_overflow_R5 : assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (qCount < capacity));

  assert_no_underflow_R4 : assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (qCount != '0));

  assert_idle_after_abort_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.abort && !stb.load) |=> txLine);

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int FRAME_BITS   = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      fifoMode,
  input  logic      wrValid,
  input  logic      clrTc,
  input  logic      qEmpty,
  input  logic      qNotFull,
  output txStrobe_t stb,
  output logic      dmaReq,
  output logic      txComplete
);

  localparam int BAUD_W = $clog2(CLKS_PER_BIT + 1);
  localparam int BIT_W  = $clog2(FRAME_BITS + 1);

  txState_t          state, stateNext;
  logic [BAUD_W-1:0] baudCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              baudEnd, lastBit, tcSet, tcFlag, counting;

  assign baudEnd  = (baudCnt == BAUD_W'(CLKS_PER_BIT - 1));
  assign lastBit  = (bitCnt == BIT_W'(FRAME_BITS - 1));
  assign counting = (state == ST_PRE) || (state == ST_SEND);

  always_comb begin
    stb       = '0;
    stb.push  = wrValid && qNotFull;
    tcSet     = 1'b0;
    stateNext = state;
    case (state)
      ST_OFF: begin
        if (txEnable) stateNext = ST_PRE;
      end
      ST_PRE: begin
        if (baudEnd && lastBit) stateNext = ST_READY;
      end
      ST_READY: begin
        if (!qEmpty) begin
          stb.load  = 1'b1;
          stateNext = ST_SEND;
        end
      end
      ST_SEND: begin
        if (baudEnd) begin
          if (!lastBit) begin
            stb.shift = 1'b1;
          end else if (!qEmpty) begin
            stb.load = 1'b1;
          end else begin
            stb.shift = 1'b1;
            tcSet     = 1'b1;
            stateNext = ST_READY;
          end
        end
      end
      default: stateNext = ST_OFF;
    endcase
    if (!txEnable) begin
      stateNext = ST_OFF;
      stb.load  = 1'b0;
      stb.shift = 1'b0;
      stb.abort = 1'b1;
      tcSet     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      baudCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state <= stateNext;
      if (!counting || stateNext != state || stb.load) begin
        baudCnt <= '0;
        bitCnt  <= '0;
      end else if (baudEnd) begin
        baudCnt <= '0;
        bitCnt  <= lastBit ? '0 : bitCnt + 1'b1;
      end else begin
        baudCnt <= baudCnt + 1'b1;
      end
    end
  end

  // Completion flag: a new byte wins, then hardware set, then software clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          tcFlag <= 1'b1;
    else if (stb.push)  tcFlag <= 1'b0;
    else if (tcSet)     tcFlag <= 1'b1;
    else if (clrTc)     tcFlag <= 1'b0;
  end

  assign txComplete = tcFlag;
  assign dmaReq     = txEnable && (fifoMode ? qNotFull : qEmpty);

  assert_tc_after_stop_R8 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(txComplete) |-> ($past(state) == ST_SEND));

  assert_write_drops_tc_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && qNotFull) |=> !txComplete);

  assert_preamble_no_load_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE || state == ST_OFF) |-> !stb.load);

  assert_clear_drops_tc_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (clrTc && !tcSet) |=> !txComplete);

endmodule

// File: rtl/uart_tx_dma.sv
module uart_tx_dma
  import uart_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8,
  parameter int FIFO_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              fifoMode,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clrTc,
  output logic              txLine,
  output logic              dmaReq,
  output logic              txEmpty,
  output logic              fifoNotFull,
  output logic              txComplete
);

  localparam int FRAME_BITS = DATA_W + 2;

  txStrobe_t stb;
  logic      qEmpty, qNotFull;

  uart_tx_ctrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .FRAME_BITS  (FRAME_BITS)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEnable  (txEnable),
    .fifoMode  (fifoMode),
    .wrValid   (wrValid),
    .clrTc     (clrTc),
    .qEmpty    (qEmpty),
    .qNotFull  (qNotFull),
    .stb       (stb),
    .dmaReq    (dmaReq),
    .txComplete(txComplete)
  );

  uart_tx_datapath #(
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .fifoMode(fifoMode),
    .wrData  (wrData),
    .txLine  (txLine),
    .qEmpty  (qEmpty),
    .qNotFull(qNotFull)
  );

  assign txEmpty     = qEmpty;
  assign fifoNotFull = qNotFull;

endmodule

// File: tb/tb_uart_tx_dma.sv
`timescale 1ns/1ps
module tb_uart_tx_dma;

  localparam int CPB   = 8;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int FRAME = 10 * CPB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          txEnable = 1'b0;
  logic          fifoMode = 1'b0;
  logic          wrValid = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          clrTc = 1'b0;
  logic          txLine, dmaReq, txEmpty, fifoNotFull, txComplete;

  int          nChecks = 0;
  int          nFails  = 0;
  logic [7:0]  expQ[$];
  longint      falls[$];
  longint      cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_dma #(.CLKS_PER_BIT(CPB), .DATA_W(DW), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .fifoMode(fifoMode),
    .wrValid(wrValid), .wrData(wrData), .clrTc(clrTc), .txLine(txLine),
    .dmaReq(dmaReq), .txEmpty(txEmpty), .fifoNotFull(fifoNotFull),
    .txComplete(txComplete)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: wait for the request like a DMA channel, write, record the expected byte.
  task automatic dmaSend(input logic [7:0] b);
    while (!dmaReq) @(negedge clk);
    wrValid = 1'b1;
    wrData  = b;
    expQ.push_back(b);
    @(negedge clk);
    wrValid = 1'b0;
    check(txComplete == 1'b0, "R7", "tc after write", txComplete, 0);
  endtask

  // Write without a request check and without expecting the byte.
  task automatic rawWrite(input logic [7:0] b);
    wrValid = 1'b1;
    wrData  = b;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitTc();
    int n = 0;
    while (!txComplete && n < 20 * FRAME) begin
      @(negedge clk);
      n++;
    end
    check(txComplete == 1'b1, "R8", "tc rises after queue drains", txComplete, 1);
    check(expQ.size() == 0, "R8", "frames left when tc rose", expQ.size(), 0);
  endtask

  // Monitor: decode frames at mid-bit and compare against the scoreboard.
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (rstN && txLine === 1'b0) begin
        falls.push_back(cyc);
        repeat (CPB / 2) @(negedge clk);
        check(txLine == 1'b0, "R2", "start bit", txLine, 0);
        for (int i = 0; i < DW; i++) begin
          repeat (CPB) @(negedge clk);
          got[i] = txLine;
        end
        repeat (CPB) @(negedge clk);
        check(txLine == 1'b1, "R2", "stop bit", txLine, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected frame (dropped write sent)", got, -1);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(got == e, "R2", "frame data", got, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    longint enCyc;
    int     idx;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txLine == 1'b1, "R1", "line idle", txLine, 1);
    check(txEmpty == 1'b1, "R1", "empty flag", txEmpty, 1);
    check(fifoNotFull == 1'b1, "R1", "not-full flag", fifoNotFull, 1);
    check(txComplete == 1'b1, "R1", "tc flag", txComplete, 1);
    check(dmaReq == 1'b0, "R1", "request while disabled", dmaReq, 0);
    check(dmaReq == 1'b0, "R6", "no request while disabled", dmaReq, 0);

    // R3 preamble in single-register mode
    idx = falls.size();
    txEnable = 1'b1;
    enCyc = cyc;
    @(negedge clk);
    dmaSend(8'hA5);
    waitTc();
    check(falls.size() > idx && (falls[idx] - (enCyc + 1)) >= FRAME,
          "R3", "preamble length", falls[idx] - (enCyc + 1), FRAME);
    check((falls[idx] - (enCyc + 1)) <= FRAME + 2, "R3", "start after preamble",
          falls[idx] - (enCyc + 1), FRAME + 1);

    // R4 single register burst, R2 back-to-back spacing, dropped write
    idx = falls.size();
    dmaSend(8'h3C);
    check(txEmpty == 1'b0, "R4", "empty low after write", txEmpty, 0);
    check(dmaReq == 1'b0, "R4", "request low while register full", dmaReq, 0);
    dmaSend(8'hC3);
    check(dmaReq == 1'b0 && fifoNotFull == 1'b0, "R4", "register full", dmaReq, 0);
    rawWrite(8'hEE);
    dmaSend(8'h01);
    dmaSend(8'hFE);
    waitTc();
    check(falls.size() == idx + 4, "R4", "frames sent in burst", falls.size() - idx, 4);
    check(falls[idx + 2] - falls[idx + 1] == FRAME, "R2", "back-to-back spacing",
          falls[idx + 2] - falls[idx + 1], FRAME);

    // R9 clear strobe
    clrTc = 1'b1;
    @(negedge clk);
    clrTc = 1'b0;
    check(txComplete == 1'b0, "R9", "cleared", txComplete, 0);
    repeat (3 * FRAME) @(negedge clk);
    check(txComplete == 1'b0, "R9", "stays cleared", txComplete, 0);
    check(txLine == 1'b1, "R9", "line idle after clear", txLine, 1);

    // R6 disable; R5 queue mode filled during preamble
    txEnable = 1'b0;
    @(negedge clk);
    check(dmaReq == 1'b0, "R6", "request low when disabled", dmaReq, 0);
    fifoMode = 1'b1;
    @(negedge clk);
    check(dmaReq == 1'b0 && fifoNotFull == 1'b1, "R6", "room but disabled", dmaReq, 0);
    idx = falls.size();
    txEnable = 1'b1;
    enCyc = cyc;
    for (int k = 0; k < DEPTH; k++) begin
      dmaSend(8'(8'h10 + 8'(k * 37)));
      if (k == 2) begin
        check(dmaReq == 1'b1, "R5", "request with room", dmaReq, 1);
        check(txEmpty == 1'b0, "R5", "empty low with 3 queued", txEmpty, 0);
      end
    end
    check(fifoNotFull == 1'b0, "R5", "queue full", fifoNotFull, 0);
    check(dmaReq == 1'b0, "R5", "request low when full", dmaReq, 0);
    rawWrite(8'h99);
    check(txLine == 1'b1, "R3", "line high in preamble", txLine, 1);
    waitTc();
    check(falls.size() == idx + DEPTH, "R5", "frames from queue", falls.size() - idx, DEPTH);
    check((falls[idx] - (enCyc + 1)) >= FRAME, "R3", "queue-mode preamble",
          falls[idx] - (enCyc + 1), FRAME);
    check(falls[idx + DEPTH - 1] - falls[idx] == (DEPTH - 1) * FRAME, "R2",
          "queue back-to-back", falls[idx + DEPTH - 1] - falls[idx], (DEPTH - 1) * FRAME);

    repeat (2 * FRAME) @(negedge clk);
    check(expQ.size() == 0, "R5", "scoreboard drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule